// File: doc/BRIEF.md
# Gated Priority Egress Selector

This block decides which of the eight egress queues of one switch port sends the next frame. A frame that arrives is steered to a queue by its 3-bit priority code, with a one-hot write enable for the queue storage. Each queue reports whether it holds frames. A time-driven gate vector and one or more cascaded shaper stages per queue can hide a queue from selection, so a blocked queue looks the same as an empty one.

All queue, gate and shaper flags are captured in a snapshot register first, and the choice is made from that snapshot one clock later. Every change presented in the same cycle is therefore seen together, so a high-priority arrival that coincides with a low-priority one is never passed over. Among the visible queues the highest-numbered one wins. The grant is held until the MAC reports that the frame is done, and the selector then looks at all queues again. A shaper that stops blocking a queue has the same effect as a frame arriving there.

Top module: `egress_prio_select`

## Requirements
- R1: While `arr_valid_i` is high, `steer_oh_o` has exactly bit `arr_pcp_i` set (bit n selects queue n). While it is low, `steer_oh_o` is all zeros. The path is combinational.
- R2: Queue q is a candidate only if `q_nonempty_i[q]` and `gate_open_i[q]` are high and every shaper stage passes it. A queue that is not a candidate is never granted.
- R3: When a grant is issued, `grant_q_o` is the highest-numbered candidate.
- R4: Inputs sampled at clock edge k produce a grant at edge k+1 (`grant_valid_o` is high after edge k+1), provided the selector is idle.
- R5: If a low-priority and a high-priority queue become non-empty in the same cycle, the high-priority queue is granted.
- R6: `grant_valid_o` and `grant_q_o` stay unchanged until `mac_done_i` is sampled high. At that edge `grant_valid_o` falls, whatever the queue inputs do in the meantime.
- R7: No grant is issued from a snapshot in which `mac_busy_i` was high.
- R8: After a done edge the selector is idle for one cycle and then grants again from the queue state sampled at the done edge.
- R9: While `rst_ni` is low, `grant_valid_o` is 0 and `grant_q_o` is 0.
- R10: `shaper_ok_i` holds NUM_STAGES stages of NUM_Q bits, with stage s, queue q at bit s*NUM_Q+q. Any stage at 0 hides the queue. When the last blocking stage returns to 1, the queue is granted exactly as for a new arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arr_valid_i | input | 1 | A frame is arriving this cycle |
| arr_pcp_i | input | 3 | Priority code of the arriving frame |
| steer_oh_o | output | 8 | One-hot write enable for the target queue |
| q_nonempty_i | input | 8 | Per-queue non-empty flags |
| gate_open_i | input | 8 | Per-queue gate state, 1 = open |
| shaper_ok_i | input | 16 | Per-stage, per-queue shaper eligibility |
| mac_busy_i | input | 1 | MAC is transmitting |
| mac_done_i | input | 1 | MAC finished the granted frame |
| grant_valid_o | output | 1 | A grant is held |
| grant_q_o | output | 3 | Granted queue index |

## Verification
The assertions assume that all inputs are driven to known values from time zero, that `mac_done_i` pulses only while a grant is held, and that the MAC raises `mac_busy_i` on its own after it sees a grant. The bench drives every input from reset onward. In the random phase it emulates a MAC that answers each grant with a busy period of random length, ending in a single-cycle done pulse. Outside a grant, busy is raised only in short random pulses while the selector is idle. Queue, gate and shaper flags change freely every cycle, because the held grant is required to ignore them.

// File: rtl/egress_sel_pkg.sv
package egress_sel_pkg;
  localparam int unsigned DEF_NUM_Q      = 8;
  localparam int unsigned DEF_NUM_STAGES = 2;

  typedef enum logic {
    SEL_IDLE = 1'b0,
    SEL_HOLD = 1'b1
  } sel_state_e;
endpackage

// File: rtl/egress_sel_steer.sv
module egress_sel_steer #(
  parameter int unsigned NUM_Q = 8,
  localparam int unsigned QW = $clog2(NUM_Q)
) (
  input  logic             arr_valid_i,
  input  logic [QW-1:0]    arr_pcp_i,
  output logic [NUM_Q-1:0] steer_oh_o
);
  for (genvar q = 0; q < NUM_Q; q++) begin : g_dec
    assign steer_oh_o[q] = arr_valid_i && (arr_pcp_i == QW'(q));
  end
endmodule

// File: rtl/egress_sel_cand.sv
module egress_sel_cand #(
  parameter int unsigned NUM_Q      = 8,
  parameter int unsigned NUM_STAGES = 2
) (
  input  logic [NUM_Q-1:0]            q_nonempty_i,
  input  logic [NUM_Q-1:0]            gate_open_i,
  input  logic [NUM_Q*NUM_STAGES-1:0] shaper_ok_i,
  output logic [NUM_Q-1:0]            cand_o
);
  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic [NUM_STAGES-1:0] stage_ok;
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_s
      assign stage_ok[s] = shaper_ok_i[s*NUM_Q+q];
    end
    // a blocked queue is indistinguishable from an empty one
    assign cand_o[q] = q_nonempty_i[q] & gate_open_i[q] & (&stage_ok);
  end
endmodule

// File: rtl/egress_sel_pick.sv
module egress_sel_pick #(
  parameter int unsigned NUM_Q = 8,
  localparam int unsigned QW = $clog2(NUM_Q)
) (
  input  logic [NUM_Q-1:0] cand_i,
  output logic             any_o,
  output logic [QW-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (cand_i[i]) idx_o = QW'(i);
    end
  end
  assign any_o = |cand_i;
endmodule

// File: rtl/egress_prio_select.sv
module egress_prio_select
  import egress_sel_pkg::*;
#(
  parameter int unsigned NUM_Q      = DEF_NUM_Q,
  parameter int unsigned NUM_STAGES = DEF_NUM_STAGES,
  localparam int unsigned QW = $clog2(NUM_Q),
  localparam int unsigned SW = NUM_Q * NUM_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arr_valid_i,
  input  logic [QW-1:0]    arr_pcp_i,
  output logic [NUM_Q-1:0] steer_oh_o,
  input  logic [NUM_Q-1:0] q_nonempty_i,
  input  logic [NUM_Q-1:0] gate_open_i,
  input  logic [SW-1:0]    shaper_ok_i,
  input  logic             mac_busy_i,
  input  logic             mac_done_i,
  output logic             grant_valid_o,
  output logic [QW-1:0]    grant_q_o
);
  logic [NUM_Q-1:0] cand_now;
  logic [NUM_Q-1:0] snap_cand_q;
  logic             snap_busy_q;
  logic             pick_any;
  logic [QW-1:0]    pick_idx;
  sel_state_e       state_q;

  egress_sel_steer #(.NUM_Q(NUM_Q)) u_steer (
    .arr_valid_i (arr_valid_i),
    .arr_pcp_i   (arr_pcp_i),
    .steer_oh_o  (steer_oh_o)
  );

  egress_sel_cand #(.NUM_Q(NUM_Q), .NUM_STAGES(NUM_STAGES)) u_cand (
    .q_nonempty_i (q_nonempty_i),
    .gate_open_i  (gate_open_i),
    .shaper_ok_i  (shaper_ok_i),
    .cand_o       (cand_now)
  );

  // snapshot: all same-cycle queue/shaper updates settle before the pick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_cand_q <= '0;
      snap_busy_q <= 1'b0;
    end else begin
      snap_cand_q <= cand_now;
      snap_busy_q <= mac_busy_i;
    end
  end

  egress_sel_pick #(.NUM_Q(NUM_Q)) u_pick (
    .cand_i (snap_cand_q),
    .any_o  (pick_any),
    .idx_o  (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEL_IDLE;
      grant_q_o <= '0;
    end else begin
      unique case (state_q)
        SEL_IDLE: begin
          if (pick_any && !snap_busy_q) begin
            state_q   <= SEL_HOLD;
            grant_q_o <= pick_idx;
          end
        end
        SEL_HOLD: begin
          if (mac_done_i) state_q <= SEL_IDLE;
        end
        default: state_q <= SEL_IDLE;
      endcase
    end
  end

  assign grant_valid_o = (state_q == SEL_HOLD);
endmodule

// File: rtl/egress_prio_select_chk.sv
module egress_prio_select_chk #(
  parameter int unsigned NUM_Q      = 8,
  parameter int unsigned NUM_STAGES = 2,
  localparam int unsigned QW = $clog2(NUM_Q),
  localparam int unsigned SW = NUM_Q * NUM_STAGES
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arr_valid_i,
  input logic [QW-1:0]    arr_pcp_i,
  input logic [NUM_Q-1:0] steer_oh_o,
  input logic [NUM_Q-1:0] q_nonempty_i,
  input logic [NUM_Q-1:0] gate_open_i,
  input logic [SW-1:0]    shaper_ok_i,
  input logic             mac_busy_i,
  input logic             mac_done_i,
  input logic             grant_valid_o,
  input logic [QW-1:0]    grant_q_o
);
  logic [NUM_Q-1:0] ref_cand;
  always_comb begin
    for (int q = 0; q < NUM_Q; q++) begin
      ref_cand[q] = q_nonempty_i[q] & gate_open_i[q];
      for (int s = 0; s < NUM_STAGES; s++) ref_cand[q] &= shaper_ok_i[s*NUM_Q+q];
    end
  end

  a_r1_steer_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_valid_i |-> steer_oh_o == (NUM_Q'(1) << arr_pcp_i));
  a_r1_steer_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arr_valid_i |-> steer_oh_o == '0);
  a_r2_granted_is_cand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_valid_o) |-> (($past(ref_cand, 2) >> grant_q_o) & NUM_Q'(1)) != '0);
  a_r3_highest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_valid_o) |-> ($past(ref_cand, 2) >> grant_q_o) == NUM_Q'(1));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && !mac_done_i) |=> (grant_valid_o && $stable(grant_q_o)));
  a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && mac_done_i) |=> !grant_valid_o);
  a_r7_no_grant_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_valid_o) |-> !$past(mac_busy_i, 2));
endmodule

bind egress_prio_select egress_prio_select_chk #(
  .NUM_Q(NUM_Q), .NUM_STAGES(NUM_STAGES)
) u_chk (.*);

// File: tb/egress_prio_select_tb_top.sv
module egress_prio_select_tb_top;
  localparam int NQ = 8;
  localparam int NS = 2;
  localparam int QW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arr_valid = 1'b0;
  logic [QW-1:0] arr_pcp = '0;
  logic [NQ-1:0] steer_oh;
  logic [NQ-1:0] nonempty = '0;
  logic [NQ-1:0] gate = '0;
  logic [NQ*NS-1:0] shok = '0;
  logic          busy = 1'b0;
  logic          done = 1'b0;
  logic          gvalid;
  logic [QW-1:0] gq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc_cnt = 0;
  string cur_tag = "R9";

  always #10 clk = ~clk;

  egress_prio_select dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arr_valid_i(arr_valid), .arr_pcp_i(arr_pcp),
    .steer_oh_o(steer_oh), .q_nonempty_i(nonempty), .gate_open_i(gate),
    .shaper_ok_i(shok), .mac_busy_i(busy), .mac_done_i(done),
    .grant_valid_o(gvalid), .grant_q_o(gq)
  );

  function automatic logic [NQ-1:0] cand_fn(logic [NQ-1:0] ne, logic [NQ-1:0] gt,
                                            logic [NQ*NS-1:0] sh);
    logic [NQ-1:0] c;
    for (int q = 0; q < NQ; q++) begin
      c[q] = ne[q] & gt[q];
      for (int s = 0; s < NS; s++) c[q] &= sh[s*NQ+q];
    end
    return c;
  endfunction

  function automatic logic [QW-1:0] hi_fn(logic [NQ-1:0] c);
    for (int q = NQ - 1; q >= 0; q--) if (c[q]) return QW'(q);
    return '0;
  endfunction

  // reference model from the requirements
  logic [NQ-1:0] m_snap;
  logic          m_sbusy, m_valid;
  logic [QW-1:0] m_q;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_snap <= '0; m_sbusy <= 1'b0; m_valid <= 1'b0; m_q <= '0;
    end else begin
      m_snap  <= cand_fn(nonempty, gate, shok);
      m_sbusy <= busy;
      if (m_valid) begin
        if (done) m_valid <= 1'b0;
      end else if (!m_sbusy && m_snap != '0) begin
        m_valid <= 1'b1;
        m_q     <= hi_fn(m_snap);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [NQ-1:0] es;
    @(negedge clk);
    cyc_cnt++;
    es = arr_valid ? (NQ'(1) << arr_pcp) : '0;
    chk(steer_oh == es, "R1", int'(steer_oh), int'(es));
    chk(gvalid == m_valid, cur_tag, int'(gvalid), int'(m_valid));
    if (m_valid) chk(gq == m_q, "R3", int'(gq), int'(m_q));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  always @(negedge clk) begin
    if (cyc_cnt > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc_cnt, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit mac_act;
    int mcnt;
    void'($urandom(32'h5eed_01));
    shok = '1;
    repeat (3) @(negedge clk);
    chk(gvalid == 1'b0, "R9", int'(gvalid), 0);
    chk(gq == '0, "R9", int'(gq), 0);
    rst_n = 1'b1;
    gate = '1;
    ticks(3);

    // R5: same-cycle low and high arrivals
    cur_tag = "R5";
    nonempty = 8'b0100_0100;
    ticks(2);
    chk(gvalid && gq == 3'd6, "R5", int'(gq), 6);

    // R6: hold despite input changes, release on done
    cur_tag = "R6";
    busy = 1'b1;
    nonempty = 8'b1000_0000;
    ticks(3);
    chk(gvalid && gq == 3'd6, "R6", int'(gq), 6);
    done = 1'b1;
    tick();
    chk(!gvalid, "R6", int'(gvalid), 0);
    done = 1'b0; busy = 1'b0;

    // R10: second stage blocks queue 7, then unblocks
    cur_tag = "R10";
    nonempty = 8'b1000_0000;
    shok[1*NQ+7] = 1'b0;
    ticks(4);
    chk(!gvalid, "R10", int'(gvalid), 0);
    shok[1*NQ+7] = 1'b1;
    ticks(2);
    chk(gvalid && gq == 3'd7, "R10", int'(gq), 7);

    // R8: re-evaluate after done
    cur_tag = "R8";
    nonempty = 8'b0001_0000;
    done = 1'b1;
    tick();
    done = 1'b0;
    chk(!gvalid, "R8", int'(gvalid), 0);
    tick();
    chk(gvalid && gq == 3'd4, "R8", int'(gq), 4);
    done = 1'b1; nonempty = '0;
    tick();
    done = 1'b0;
    ticks(2);

    // R7: busy blocks a new grant
    cur_tag = "R7";
    busy = 1'b1;
    nonempty = 8'b0000_0010;
    ticks(4);
    chk(!gvalid, "R7", int'(gvalid), 0);
    busy = 1'b0;
    ticks(2);
    chk(gvalid && gq == 3'd1, "R7", int'(gq), 1);
    done = 1'b1; nonempty = '0;
    tick();
    done = 1'b0;

    // R2: closed gate hides a queue
    cur_tag = "R2";
    gate = 8'b1101_1111;
    nonempty = 8'b0010_0000;
    ticks(4);
    chk(!gvalid, "R2", int'(gvalid), 0);
    gate = '1;
    ticks(2);
    chk(gvalid && gq == 3'd5, "R4", int'(gq), 5);
    done = 1'b1; nonempty = '0;
    tick();
    done = 1'b0;
    ticks(2);

    // random phase with emulated MAC
    cur_tag = "R4";
    mac_act = 1'b0; mcnt = 0;
    for (int i = 0; i < 4000; i++) begin
      arr_valid = ($urandom % 2) == 0;
      arr_pcp   = QW'($urandom);
      nonempty  = NQ'($urandom) & NQ'($urandom);
      gate      = NQ'($urandom) | NQ'($urandom);
      for (int b = 0; b < NQ*NS; b++) shok[b] = ($urandom % 5) != 0;
      if (done) begin
        done = 1'b0; busy = 1'b0;
      end else if (mac_act) begin
        if (mcnt == 0) begin done = 1'b1; mac_act = 1'b0; end
        else mcnt--;
      end else if (gvalid) begin
        mac_act = 1'b1; busy = 1'b1; mcnt = $urandom % 4;
      end else begin
        busy = ($urandom % 10) == 0;
      end
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule